// File: doc/BRIEF.md
# Four-Address I2C Target Interface

This block lets a small processor act as a target on a two-wire serial bus (one data line, one clock line, both open-drain). The bus lines are oversampled by the much faster system clock. The block recognises START and STOP, shifts in the 7-bit address that follows START, and compares it against four address registers. If any of them is equal, the block acknowledges. It then moves data bytes between the bus and a single data register. An interrupt flag is raised after every byte in either direction.

The processor side is a plain register port. Writes and reads complete in the cycle they are presented, and read data is combinational from the address. Neither side of this port applies back-pressure. The bus cannot be held either: the block never stretches the clock. In transmit mode, software has to refill the data register before the falling clock edge that ends the master's acknowledge bit. In receive mode, software has to read a byte before the next byte completes.

Register map, by `cpu_addr`:
- 0: control. Bit 0 is the interface reset (read/write). Bit 1 is the direction flag (read-only). Bit 2 is the byte interrupt flag (read-only).
- 1: data.
- 4 to 7: address slots 0 to 3, with the address in bits 6:0.

Top module: `i2c_quad_addr_slave`

## Requirements
- R1: After `rst_n` the registers read as follows: control 0x00, data 0x00, slot 0 0x55, and slots 1, 2 and 3 0x7F.
- R2: A START followed by an address byte whose upper 7 bits equal any slot is acknowledged. The block pulls SDA low (`sda_oe`=1) during the ninth clock.
- R3: An address matching no slot gets no acknowledge. It sets no interrupt, and the data register is left unchanged for the rest of that transfer.
- R4: In receive mode (address LSB 0), each data byte is stored in the data register MSB first and is acknowledged.
- R5: At the address acknowledge, the direction flag (control bit 1) takes the address LSB. When that LSB is 1, the data register is shifted out MSB first. The first bit is driven after the acknowledge clock falls.
- R6: The interrupt flag (control bit 2, also on `irq_o`) is set after each byte received or transmitted. A read or a write of the data register clears it.
- R7: If a data-register access and a byte completion fall in the same cycle, the flag stays set. The data register ends holding the new byte, and the read in that cycle returns the old byte.
- R8: In transmit mode SDA is released for the master's acknowledge bit. A NACK there returns the block to idle, and SDA stays released on further clocks.
- R9: A STOP or a repeated START in the middle of a byte abandons the byte without setting the interrupt. After a repeated START, a new address is matched.
- R10: While control bit 0 is 1, the bus logic is held idle and no address is acknowledged.
- R11: Software writes to an address slot take effect for the next address match.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than the serial clock |
| rst_n | input | 1 | Asynchronous-free active-low reset, sampled on clk |
| scl_i | input | 1 | Serial clock line as seen on the pad |
| sda_i | input | 1 | Serial data line as seen on the pad |
| sda_oe | output | 1 | 1 pulls the data line low, 0 releases it |
| cpu_addr | input | 3 | Register select |
| cpu_wr | input | 1 | Register write strobe, one cycle |
| cpu_rd | input | 1 | Register read strobe, one cycle (clears interrupt on data) |
| cpu_wdata | input | 8 | Write data |
| cpu_rdata | output | 8 | Read data for `cpu_addr` |
| irq_o | output | 1 | Byte interrupt flag |

## Verification
Two functions can land in the same cycle: the bus engine setting the interrupt and storing a received byte, and software touching the data register, which clears the interrupt. The bench provokes this by counting the synchronizer and pipeline registers from the eighth rising serial clock. It then issues the data-register read in exactly the cycle in which the completed byte reaches the register file. It judges the result three ways: the read must return the previous byte, `irq_o` must still be high afterwards, and a later read must return the new byte.

// File: rtl/i2c_qs_pkg.sv
package i2c_qs_pkg;
  localparam int ADDR_W = 7;
  localparam int DATA_W = 8;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ACK_SETUP,
    ST_ACK_HOLD,
    ST_RX,
    ST_TX,
    ST_MACK,
    ST_TX_NEXT
  } slv_state_e;

  function automatic logic [ADDR_W-1:0] slot_reset_value(int idx);
    return (idx == 0) ? 7'h55 : 7'h7F;
  endfunction
endpackage

// File: rtl/i2c_qs_sync.sv
module i2c_qs_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  logic [STAGES-1:0] scl_ff, sda_ff;
  logic scl_q, sda_q, scl_s;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      scl_ff <= '1;
      sda_ff <= '1;
      scl_q  <= 1'b1;
      sda_q  <= 1'b1;
    end else begin
      scl_ff <= {scl_ff[STAGES-2:0], scl_i};
      sda_ff <= {sda_ff[STAGES-2:0], sda_i};
      scl_q  <= scl_ff[STAGES-1];
      sda_q  <= sda_ff[STAGES-1];
    end
  end

  assign scl_s     = scl_ff[STAGES-1];
  assign sda_s     = sda_ff[STAGES-1];
  assign scl_rise  = scl_s & ~scl_q;
  assign scl_fall  = ~scl_s & scl_q;
  assign start_det = scl_s & scl_q & sda_q & ~sda_s;
  assign stop_det  = scl_s & scl_q & ~sda_q & sda_s;
endmodule

// File: rtl/i2c_qs_fsm.sv
module i2c_qs_fsm
  import i2c_qs_pkg::*;
#(
  parameter int NUM_ADDR = 4
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             srst,
  input  logic                             scl_rise,
  input  logic                             scl_fall,
  input  logic                             start_det,
  input  logic                             stop_det,
  input  logic                             sda_s,
  input  logic [NUM_ADDR-1:0][ADDR_W-1:0]  own_addr,
  input  logic [DATA_W-1:0]                tx_data,
  output logic                             sda_oe,
  output logic                             byte_done,
  output logic                             rx_wr,
  output logic [DATA_W-1:0]                rx_byte,
  output logic                             dir_load,
  output logic                             dir_val
);
  localparam int CNT_W = $clog2(DATA_W + 1);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(DATA_W - 1);
  localparam logic [CNT_W-1:0] ALL_BITS = CNT_W'(DATA_W);

  slv_state_e          state;
  logic [CNT_W-1:0]    cnt;
  logic [DATA_W-1:0]   shreg;
  logic                tx_mode;
  logic [NUM_ADDR-1:0] hit;

  for (genvar g = 0; g < NUM_ADDR; g++) begin : g_cmp
    assign hit[g] = (shreg[ADDR_W-1:0] == own_addr[g]);
  end

  assign rx_byte = shreg;

  always_ff @(posedge clk) begin
    if (!rst_n || srst) begin
      state     <= ST_IDLE;
      cnt       <= '0;
      shreg     <= '0;
      tx_mode   <= 1'b0;
      sda_oe    <= 1'b0;
      byte_done <= 1'b0;
      rx_wr     <= 1'b0;
      dir_load  <= 1'b0;
      dir_val   <= 1'b0;
    end else begin
      byte_done <= 1'b0;
      rx_wr     <= 1'b0;
      dir_load  <= 1'b0;
      if (start_det) begin
        state  <= ST_ADDR;
        cnt    <= '0;
        sda_oe <= 1'b0;
      end else if (stop_det) begin
        state  <= ST_IDLE;
        sda_oe <= 1'b0;
      end else begin
        unique case (state)
          ST_IDLE: ;
          ST_ADDR: if (scl_rise) begin
            shreg <= {shreg[DATA_W-2:0], sda_s};
            cnt   <= cnt + 1'b1;
            if (cnt == LAST_BIT) begin
              if (|hit) begin
                state    <= ST_ACK_SETUP;
                tx_mode  <= sda_s;
                dir_load <= 1'b1;
                dir_val  <= sda_s;
              end else begin
                state <= ST_IDLE;
              end
            end
          end
          ST_ACK_SETUP: if (scl_fall) begin
            sda_oe <= 1'b1;
            state  <= ST_ACK_HOLD;
          end
          ST_ACK_HOLD, ST_TX_NEXT: if (scl_fall) begin
            cnt <= '0;
            if (tx_mode) begin
              shreg  <= tx_data;
              sda_oe <= ~tx_data[DATA_W-1];
              state  <= ST_TX;
            end else begin
              sda_oe <= 1'b0;
              state  <= ST_RX;
            end
          end
          ST_RX: if (scl_rise) begin
            shreg <= {shreg[DATA_W-2:0], sda_s};
            cnt   <= cnt + 1'b1;
            if (cnt == LAST_BIT) begin
              rx_wr     <= 1'b1;
              byte_done <= 1'b1;
              state     <= ST_ACK_SETUP;
            end
          end
          ST_TX: begin
            if (scl_rise) begin
              cnt <= cnt + 1'b1;
            end else if (scl_fall) begin
              if (cnt == ALL_BITS) begin
                sda_oe    <= 1'b0;
                byte_done <= 1'b1;
                state     <= ST_MACK;
              end else begin
                shreg  <= {shreg[DATA_W-2:0], 1'b0};
                sda_oe <= ~shreg[DATA_W-2];
              end
            end
          end
          ST_MACK: if (scl_rise) begin
            state <= sda_s ? ST_IDLE : ST_TX_NEXT;
          end
          default: state <= ST_IDLE;
        endcase
      end
    end
  end

  // R2: acknowledge is held low for the whole ninth clock
  a_r2_ack_drives: assert property (@(posedge clk) disable iff (!rst_n || srst)
    state == ST_ACK_HOLD |-> sda_oe);
  // R8: line released while the master answers
  a_r8_mack_released: assert property (@(posedge clk) disable iff (!rst_n || srst)
    state == ST_MACK |-> !sda_oe);
  // R9: STOP returns to idle
  a_r9_stop_idles: assert property (@(posedge clk) disable iff (!rst_n || srst)
    stop_det |=> state == ST_IDLE);
  // R3: no byte event while matching or idle
  a_r3_no_byte_addressing: assert property (@(posedge clk) disable iff (!rst_n || srst)
    (state == ST_ADDR || state == ST_IDLE) |=> !byte_done);
endmodule

// File: rtl/i2c_qs_regs.sv
module i2c_qs_regs
  import i2c_qs_pkg::*;
#(
  parameter int NUM_ADDR = 4,
  parameter int REG_AW   = 3
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic [REG_AW-1:0]               cpu_addr,
  input  logic                            cpu_wr,
  input  logic                            cpu_rd,
  input  logic [DATA_W-1:0]               cpu_wdata,
  output logic [DATA_W-1:0]               cpu_rdata,
  input  logic                            rx_wr,
  input  logic [DATA_W-1:0]               rx_byte,
  input  logic                            byte_done,
  input  logic                            dir_load,
  input  logic                            dir_val,
  output logic [NUM_ADDR-1:0][ADDR_W-1:0] own_addr,
  output logic [DATA_W-1:0]               tx_data,
  output logic                            soft_rst,
  output logic                            irq
);
  localparam logic [REG_AW-1:0] CTRL_OFS  = REG_AW'(0);
  localparam logic [REG_AW-1:0] DATA_OFS  = REG_AW'(1);
  localparam int                ADDR_BASE = 4;

  logic dir;
  logic data_acc, data_wr, ctrl_wr;

  assign data_acc = (cpu_wr || cpu_rd) && (cpu_addr == DATA_OFS);
  assign data_wr  = cpu_wr && (cpu_addr == DATA_OFS);
  assign ctrl_wr  = cpu_wr && (cpu_addr == CTRL_OFS);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      soft_rst <= 1'b0;
      irq      <= 1'b0;
      dir      <= 1'b0;
      tx_data  <= '0;
    end else begin
      if (ctrl_wr) soft_rst <= cpu_wdata[0];
      if (soft_rst) begin
        irq <= 1'b0;
        dir <= 1'b0;
      end else begin
        if (byte_done)     irq <= 1'b1;
        else if (data_acc) irq <= 1'b0;
        if (dir_load) dir <= dir_val;
      end
      if (rx_wr)        tx_data <= rx_byte;
      else if (data_wr) tx_data <= cpu_wdata;
    end
  end

  for (genvar g = 0; g < NUM_ADDR; g++) begin : g_slot
    logic [ADDR_W-1:0] slot_q;
    always_ff @(posedge clk) begin
      if (!rst_n) slot_q <= slot_reset_value(g);
      else if (cpu_wr && cpu_addr == REG_AW'(ADDR_BASE + g)) slot_q <= cpu_wdata[ADDR_W-1:0];
    end
    assign own_addr[g] = slot_q;
  end

  always_comb begin
    cpu_rdata = '0;
    if (cpu_addr == CTRL_OFS) cpu_rdata = DATA_W'({irq, dir, soft_rst});
    else if (cpu_addr == DATA_OFS) cpu_rdata = tx_data;
    for (int i = 0; i < NUM_ADDR; i++)
      if (cpu_addr == REG_AW'(ADDR_BASE + i)) cpu_rdata = DATA_W'(own_addr[i]);
  end

  // R7: a completed byte wins over a same-cycle clear
  a_r7_set_beats_clear: assert property (@(posedge clk) disable iff (!rst_n || soft_rst)
    byte_done |=> irq);
  // R6: data access alone clears the flag
  a_r6_access_clears: assert property (@(posedge clk) disable iff (!rst_n || soft_rst)
    data_acc && !byte_done |=> !irq);
  // R5: direction flag follows the address R/W bit
  a_r5_dir_follows: assert property (@(posedge clk) disable iff (!rst_n || soft_rst)
    dir_load |=> dir == $past(dir_val));
endmodule

// File: rtl/i2c_quad_addr_slave.sv
module i2c_quad_addr_slave
  import i2c_qs_pkg::*;
#(
  parameter int NUM_ADDR    = 4,
  parameter int REG_AW      = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_oe,
  input  logic [REG_AW-1:0] cpu_addr,
  input  logic              cpu_wr,
  input  logic              cpu_rd,
  input  logic [7:0]        cpu_wdata,
  output logic [7:0]        cpu_rdata,
  output logic              irq_o
);
  logic sda_s, scl_rise, scl_fall, start_det, stop_det;
  logic soft_rst, byte_done, rx_wr, dir_load, dir_val;
  logic [DATA_W-1:0] rx_byte, tx_data;
  logic [NUM_ADDR-1:0][ADDR_W-1:0] own_addr;

  i2c_qs_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
    .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det)
  );

  i2c_qs_fsm #(.NUM_ADDR(NUM_ADDR)) u_fsm (
    .clk(clk), .rst_n(rst_n), .srst(soft_rst),
    .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det), .sda_s(sda_s),
    .own_addr(own_addr), .tx_data(tx_data), .sda_oe(sda_oe),
    .byte_done(byte_done), .rx_wr(rx_wr), .rx_byte(rx_byte),
    .dir_load(dir_load), .dir_val(dir_val)
  );

  i2c_qs_regs #(.NUM_ADDR(NUM_ADDR), .REG_AW(REG_AW)) u_regs (
    .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_wr(cpu_wr),
    .cpu_rd(cpu_rd), .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata),
    .rx_wr(rx_wr), .rx_byte(rx_byte), .byte_done(byte_done),
    .dir_load(dir_load), .dir_val(dir_val), .own_addr(own_addr),
    .tx_data(tx_data), .soft_rst(soft_rst), .irq(irq_o)
  );

  // R10: held interface never pulls the data line
  a_r10_soft_reset_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst && $past(soft_rst) |-> !sda_oe);
endmodule

// File: tb/i2c_quad_addr_slave_tb_top.sv
module i2c_quad_addr_slave_tb_top;
  localparam int H = 12;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic       rst_n = 1'b0;
  logic       scl_m = 1'b1, sda_m = 1'b1;
  logic       sda_oe, sda_line, irq_o;
  logic [2:0] cpu_addr = '0;
  logic       cpu_wr = 1'b0, cpu_rd = 1'b0;
  logic [7:0] cpu_wdata = '0, cpu_rdata;

  int n_chk = 0, n_fail = 0, m_chk = 0, m_fail = 0;
  logic [7:0] exp_q[$];
  logic       mon_tx = 1'b0;
  int         mon_bit = 0;
  logic [7:0] mon_sh = '0;

  assign sda_line = sda_m & ~sda_oe;

  i2c_quad_addr_slave dut_i (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line), .sda_oe(sda_oe),
    .cpu_addr(cpu_addr), .cpu_wr(cpu_wr), .cpu_rd(cpu_rd),
    .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata), .irq_o(irq_o)
  );

  // scoreboard monitor: gathers bytes the block sends and compares with the queue
  always @(posedge scl_m) begin
    if (mon_tx) begin
      if (mon_bit < 8) begin
        mon_sh  = {mon_sh[6:0], sda_line};
        mon_bit = mon_bit + 1;
        if (mon_bit == 8) begin
          m_chk++;
          if (exp_q.size() == 0) begin
            m_fail++;
            $display("FAIL R5 unexpected byte got %h expected none", mon_sh);
          end else begin
            logic [7:0] e;
            e = exp_q.pop_front();
            if (mon_sh !== e) begin
              m_fail++;
              $display("FAIL R5 sent byte got %h expected %h", mon_sh, e);
            end
          end
        end
      end else begin
        mon_bit = 0;
      end
    end
  end

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk + m_chk, n_fail + m_fail);
  endtask

  task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s got %h expected %h", tag, act, exp);
    end
  endtask

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic reg_wr(logic [2:0] a, logic [7:0] d);
    cpu_addr = a; cpu_wdata = d; cpu_wr = 1'b1;
    @(negedge clk);
    cpu_wr = 1'b0;
  endtask

  task automatic reg_rd(logic [2:0] a, output logic [7:0] d);
    cpu_addr = a; cpu_rd = 1'b1;
    #1 d = cpu_rdata;
    @(negedge clk);
    cpu_rd = 1'b0;
  endtask

  task automatic bus_start();
    sda_m = 1'b1; tick(H); scl_m = 1'b1; tick(H); sda_m = 1'b0; tick(H); scl_m = 1'b0; tick(2);
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; tick(H); scl_m = 1'b1; tick(H); sda_m = 1'b1; tick(H);
  endtask

  task automatic write_bit(logic b);
    sda_m = b; tick(H); scl_m = 1'b1; tick(H); scl_m = 1'b0; tick(2);
  endtask

  task automatic read_bit(output logic b);
    sda_m = 1'b1; tick(H); scl_m = 1'b1; tick(H/2); b = sda_line; tick(H/2); scl_m = 1'b0; tick(2);
  endtask

  task automatic send_byte(logic [7:0] v, output logic ack);
    for (int i = 7; i >= 0; i--) write_bit(v[i]);
    read_bit(ack);
  endtask

  task automatic recv_byte(output logic [7:0] v, input logic nack, input logic refill, input logic [7:0] nxt);
    logic b;
    v = '0;
    for (int i = 0; i < 8; i++) begin
      read_bit(b);
      v = {v[6:0], b};
    end
    tick(4);
    chk("R6 irq after sent byte", 8'(irq_o), 8'h01);
    if (refill) begin
      reg_wr(3'd1, nxt);
      chk("R6 data write clears irq", 8'(irq_o), 8'h00);
    end
    write_bit(nack);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired got timeout expected completion");
    summary();
    $finish;
  end

  initial begin : main
    logic [7:0] d;
    logic ack, b;
    tick(5);
    rst_n = 1'b1;
    tick(3);

    // R1 reset values
    reg_rd(3'd0, d); chk("R1 control", d, 8'h00);
    reg_rd(3'd1, d); chk("R1 data", d, 8'h00);
    reg_rd(3'd4, d); chk("R1 slot0", d, 8'h55);
    reg_rd(3'd5, d); chk("R1 slot1", d, 8'h7F);
    reg_rd(3'd6, d); chk("R1 slot2", d, 8'h7F);
    reg_rd(3'd7, d); chk("R1 slot3", d, 8'h7F);

    // R2 / R4 write one byte to slot0 address
    bus_start();
    send_byte({7'h55, 1'b0}, ack); chk("R2 ack slot0", 8'(ack), 8'h00);
    send_byte(8'hA3, ack);         chk("R4 data ack", 8'(ack), 8'h00);
    chk("R6 irq after rx", 8'(irq_o), 8'h01);
    reg_rd(3'd0, d); chk("R5 dir 0 irq 1", d, 8'h04);
    reg_rd(3'd1, d); chk("R4 data stored", d, 8'hA3);
    chk("R6 read clears irq", 8'(irq_o), 8'h00);
    bus_stop();

    // R11 reprogram slot2, two bytes
    reg_wr(3'd6, 8'h21);
    reg_rd(3'd6, d); chk("R11 slot2 readback", d, 8'h21);
    bus_start();
    send_byte({7'h21, 1'b0}, ack); chk("R11 new address ack", 8'(ack), 8'h00);
    send_byte(8'h11, ack);
    reg_rd(3'd1, d); chk("R4 first byte", d, 8'h11);
    send_byte(8'hE8, ack);
    reg_rd(3'd1, d); chk("R4 second byte", d, 8'hE8);
    bus_stop();

    // R5 / R8 transmit two bytes, NACK the last
    reg_wr(3'd1, 8'hC6);
    exp_q.push_back(8'hC6);
    exp_q.push_back(8'h5A);
    bus_start();
    send_byte({7'h21, 1'b1}, ack); chk("R2 ack read address", 8'(ack), 8'h00);
    reg_rd(3'd0, d); chk("R5 dir set", d, 8'h02);
    mon_tx = 1'b1;
    recv_byte(d, 1'b0, 1'b1, 8'h5A); chk("R5 first sent", d, 8'hC6);
    recv_byte(d, 1'b1, 1'b0, 8'h00); chk("R5 second sent", d, 8'h5A);
    mon_tx = 1'b0;
    read_bit(b); chk("R8 released after nack", 8'(b), 8'h01);
    chk("R8 no drive", 8'(sda_oe), 8'h00);
    bus_stop();
    chk("R5 scoreboard drained", 8'(exp_q.size()), 8'h00);
    reg_rd(3'd1, d);

    // R9 stop mid byte, then repeated start mid byte
    bus_start();
    send_byte({7'h55, 1'b0}, ack);
    write_bit(1'b1); write_bit(1'b0); write_bit(1'b1); write_bit(1'b0);
    bus_stop();
    chk("R9 no irq after stop", 8'(irq_o), 8'h00);
    reg_rd(3'd1, d); chk("R9 data kept", d, 8'h5A);
    bus_start();
    send_byte({7'h55, 1'b0}, ack);
    write_bit(1'b0); write_bit(1'b1); write_bit(1'b1);
    bus_start();
    chk("R9 no irq after restart", 8'(irq_o), 8'h00);
    send_byte({7'h7F, 1'b0}, ack); chk("R9 restart address ack", 8'(ack), 8'h00);
    send_byte(8'h3C, ack);
    reg_rd(3'd1, d); chk("R9 byte after restart", d, 8'h3C);
    bus_stop();

    // R3 no match
    bus_start();
    send_byte({7'h30, 1'b0}, ack); chk("R3 no ack", 8'(ack), 8'h01);
    send_byte(8'hFF, ack);         chk("R3 data not acked", 8'(ack), 8'h01);
    bus_stop();
    chk("R3 no irq", 8'(irq_o), 8'h00);
    reg_rd(3'd1, d); chk("R3 data unchanged", d, 8'h3C);

    // R10 interface reset
    reg_wr(3'd0, 8'h01);
    reg_rd(3'd0, d); chk("R10 control bit", d, 8'h01);
    bus_start();
    send_byte({7'h55, 1'b0}, ack); chk("R10 held no ack", 8'(ack), 8'h01);
    bus_stop();
    reg_wr(3'd0, 8'h00);
    bus_start();
    send_byte({7'h55, 1'b0}, ack); chk("R10 released ack", 8'(ack), 8'h00);
    bus_stop();

    // R7 byte completion and data read in the same cycle
    bus_start();
    send_byte({7'h55, 1'b0}, ack);
    begin
      logic [7:0] rb;
      rb = 8'h96;
      for (int i = 7; i >= 1; i--) write_bit(rb[i]);
      sda_m = rb[0]; tick(H);
      scl_m = 1'b1;
      tick(3);
      cpu_addr = 3'd1; cpu_rd = 1'b1;
      #1 d = cpu_rdata;
      @(negedge clk);
      cpu_rd = 1'b0;
      chk("R7 race read old", d, 8'h3C);
      tick(H - 4);
      scl_m = 1'b0; tick(2);
    end
    read_bit(ack); chk("R7 ack", 8'(ack), 8'h00);
    chk("R7 irq survives", 8'(irq_o), 8'h01);
    reg_rd(3'd1, d); chk("R7 new byte", d, 8'h96);
    chk("R7 later read clears", 8'(irq_o), 8'h00);
    bus_stop();

    tick(10);
    summary();
    $finish;
  end
endmodule